// File: doc/BRIEF.md
# Programmable Decade Down-Count Frequency Divider

This block divides an incoming clock by a modulus chosen on switch-style digit inputs. The input first passes through a divide-by-two. Every counted step then happens on the halved rate. A chain of down-counting digit stages (tenths decade, units decade, tens decade, and a top stage that counts by eight) steps toward zero. Each stage borrows from the stage above it.

When the whole chain reads zero, a two-flip-flop sequencer takes over and runs the reload, spending one halved clock in each phase:
1. It initializes the stages to a known count.
2. It holds them inhibited.
3. It fires a preload that copies the digit settings into the stages.
4. It releases the count again.

The handshake steps are part of the period. The full modulus is therefore the programmed value plus a fixed offset of four halved clocks.

Each period produces one output pulse, one input clock wide. A count strobe marks every halved clock that the chain actually counts. The digit settings are read only at the preload. Decimal digit inputs above nine are read as nine.

Top module: `decade_divn`

## Requirements
- R1: After reset the chain holds zero, both sequencer flip-flops are clear, and `div_out` and `cnt_strobe` are low. Because the all-zero condition starts a reload at once, the first `div_out` pulse follows within 10 input clocks of reset release.
- R2: With V = tenths + 10·units + 100·tens + 1000·eights, consecutive `div_out` pulses are exactly 2·(V+4) input clocks apart.
- R3: All counting and sequencing run on alternate input clocks, as set by the divide-by-two. `cnt_strobe` is never high on two consecutive clocks.
- R4: Each decimal digit stage stays in 0..9 and the top stage stays in 0..7. A stage that borrows at zero wraps to its maximum.
- R5: On the terminal count the sequencer runs in order: initialize (first flip-flop set), then inhibit (both set), then preload (first cleared while the second stays set), then release (both clear). Each step takes one halved clock.
- R6: No count is taken during the handshake. Exactly V `cnt_strobe` pulses occur between two consecutive `div_out` pulses, and `cnt_strobe` is low in the clock after a `div_out` pulse.
- R7: A decimal digit input above 9 (4'hA..4'hF) is loaded as 9.
- R8: `div_out` is high for exactly one input clock per period.
- R9: The digit inputs are sampled only at the preload. A change made during a countdown leaves that period's length unchanged and takes effect from the next reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input signal to divide, used as the clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| set_tenths | input | 4 | BCD digit for the tenths decade |
| set_units | input | 4 | BCD digit for the units decade |
| set_tens | input | 4 | BCD digit for the tens decade |
| set_eights | input | 3 | Digit for the divide-by-eight stage (weight 1000) |
| div_out | output | 1 | Divided output, one clock wide per period |
| cnt_strobe | output | 1 | One clock wide on each counted halved clock |

## Verification
The assertions check on every cycle that each digit stage stays within its range and that the sequencer steps through initialize, inhibit and preload in order. They also check that neither output pulse lasts longer than one clock, and that no count follows an output pulse.

The exact period for a given setting can only be shown by the bench scenarios, which measure pulse spacing and strobe counts. The same holds for the clamping of out-of-range digits, the timing of the first pulse after reset, and the rule that settings take effect only at the next preload.

// File: rtl/divn_pkg.sv
package divn_pkg;
  localparam int DIG_W = 4;
  localparam int N_STG = 4;
  localparam int HANDSHAKE_TICKS = 4;

  typedef logic [DIG_W-1:0] digit_t;

  function automatic int stage_mod(input int idx);
    return (idx == N_STG - 1) ? 8 : 10;
  endfunction

  function automatic digit_t clamp_dec(input digit_t d);
    return (d > digit_t'(9)) ? digit_t'(9) : d;
  endfunction
endpackage

// File: rtl/half_rate.sv
module half_rate (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  logic tog_q, tog_d;

  always_comb tog_d = ~tog_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tog_q <= 1'b0;
    else        tog_q <= tog_d;
  end

  assign tick = tog_q;
endmodule

// File: rtl/digit_stage.sv
module digit_stage #(
  parameter int W   = 4,
  parameter int MOD = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] val,
  output logic         is_zero
);
  localparam logic [W-1:0] TOP = W'(MOD - 1);

  logic [W-1:0] val_q, val_d;

  always_comb begin
    val_d = val_q;
    if (clr)       val_d = '0;
    else if (load) val_d = load_val;
    else if (dec)  val_d = (val_q == '0) ? TOP : val_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= '0;
    else        val_q <= val_d;
  end

  assign val     = val_q;
  assign is_zero = (val_q == '0);

  assert_digit_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    val_q <= TOP);
endmodule

// File: rtl/reload_seq.sv
module reload_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic chain_zero,
  output logic init_lvl,
  output logic inhibit_lvl,
  output logic preload,
  output logic count_en,
  output logic term
);
  logic fa_q, fa_d, fb_q, fb_d;
  logic running;

  assign running = ~fa_q & ~fb_q;

  always_comb begin
    fa_d = fa_q;
    fb_d = fb_q;
    if (tick) begin
      if (running && chain_zero) fa_d = 1'b1;
      else if (fa_q && !fb_q)    fb_d = 1'b1;
      else if (fa_q && fb_q)     fa_d = 1'b0;
      else if (!fa_q && fb_q)    fb_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fa_q <= 1'b0;
      fb_q <= 1'b0;
    end else begin
      fa_q <= fa_d;
      fb_q <= fb_d;
    end
  end

  assign init_lvl    = fa_q & ~fb_q;
  assign inhibit_lvl = fb_q;
  assign preload     = tick & fa_q & fb_q;
  assign count_en    = tick & running & ~chain_zero;
  assign term        = tick & running & chain_zero;

  assert_init_to_inhibit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && fa_q && !fb_q) |=> (fa_q && fb_q));
  assert_inhibit_to_preload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && fa_q && fb_q) |=> (!fa_q && fb_q));
  assert_preload_to_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !fa_q && fb_q) |=> (!fa_q && !fb_q));
  assert_term_starts_init_R5: assert property (@(posedge clk) disable iff (!rst_n)
    term |=> (fa_q && !fb_q));
endmodule

// File: rtl/decade_divn.sv
module decade_divn
  import divn_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] set_tenths,
  input  logic [3:0] set_units,
  input  logic [3:0] set_tens,
  input  logic [2:0] set_eights,
  output logic       div_out,
  output logic       cnt_strobe
);
  logic [1:0] rsync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  logic tick;
  half_rate u_half (.clk(clk), .rst_n(srst_n), .tick(tick));

  digit_t [N_STG-1:0] ld_val;
  digit_t [N_STG-1:0] stg_val;
  logic   [N_STG-1:0] stg_zero;
  logic   [N_STG:0]   low_zero;

  assign ld_val[0] = clamp_dec(set_tenths);
  assign ld_val[1] = clamp_dec(set_units);
  assign ld_val[2] = clamp_dec(set_tens);
  assign ld_val[3] = {1'b0, set_eights};

  logic init_lvl, inhibit_lvl, preload, count_en, term, chain_zero;

  assign low_zero[0] = 1'b1;
  assign chain_zero  = low_zero[N_STG];

  for (genvar i = 0; i < N_STG; i++) begin : g_stage
    digit_stage #(.W(DIG_W), .MOD(stage_mod(i))) u_stg (
      .clk     (clk),
      .rst_n   (srst_n),
      .clr     (init_lvl & tick),
      .load    (preload),
      .load_val(ld_val[i]),
      .dec     (count_en & low_zero[i]),
      .val     (stg_val[i]),
      .is_zero (stg_zero[i])
    );
    assign low_zero[i+1] = low_zero[i] & stg_zero[i];
  end

  reload_seq u_seq (
    .clk        (clk),
    .rst_n      (srst_n),
    .tick       (tick),
    .chain_zero (chain_zero),
    .init_lvl   (init_lvl),
    .inhibit_lvl(inhibit_lvl),
    .preload    (preload),
    .count_en   (count_en),
    .term       (term)
  );

  logic out_q, out_d, stb_q, stb_d;

  always_comb begin
    out_d = term;
    stb_d = count_en;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      out_q <= 1'b0;
      stb_q <= 1'b0;
    end else begin
      out_q <= out_d;
      stb_q <= stb_d;
    end
  end

  assign div_out    = out_q;
  assign cnt_strobe = stb_q;

  assert_pulse_width_R8: assert property (@(posedge clk) disable iff (!srst_n)
    div_out |=> !div_out);
  assert_strobe_alternate_R3: assert property (@(posedge clk) disable iff (!srst_n)
    cnt_strobe |=> !cnt_strobe);
  assert_no_count_after_term_R6: assert property (@(posedge clk) disable iff (!srst_n)
    div_out |=> !cnt_strobe);
  assert_no_count_while_inhibit_R6: assert property (@(posedge clk) disable iff (!srst_n)
    (inhibit_lvl || init_lvl) |=> !cnt_strobe);
endmodule

// File: tb/sim_decade_divn.sv
module sim_decade_divn;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] set_tenths = '0, set_units = '0, set_tens = '0;
  logic [2:0] set_eights = '0;
  logic       div_out, cnt_strobe;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5ns clk = ~clk;

  decade_divn u0 (
    .clk(clk), .rst_n(rst_n), .set_tenths(set_tenths), .set_units(set_units),
    .set_tens(set_tens), .set_eights(set_eights),
    .div_out(div_out), .cnt_strobe(cnt_strobe)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input int t, input int u, input int h, input int e);
    @(negedge clk);
    set_tenths = 4'(t); set_units = 4'(u); set_tens = 4'(h); set_eights = 3'(e);
  endtask

  task automatic wait_pulse();
    for (int k = 0; k < 40000; k++) begin
      @(negedge clk);
      if (div_out) return;
    end
  endtask

  // from one pulse to the next: clocks apart, strobes between, width ok
  task automatic measure(output int per, output int stb, output int wid_ok,
                         output int pair_ok);
    int prev;
    per = 0; stb = 0; wid_ok = 1; pair_ok = 1; prev = 0;
    wait_pulse();
    for (int k = 0; k < 40000; k++) begin
      @(negedge clk);
      per++;
      if (k == 0 && div_out) wid_ok = 0;
      if (cnt_strobe && prev) pair_ok = 0;
      prev = int'(cnt_strobe);
      if (div_out) return;
      if (cnt_strobe) stb++;
    end
  endtask

  task automatic t_reset();
    int first;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 div_out in reset", int'(div_out), 0);
    check("R1 cnt_strobe in reset", int'(cnt_strobe), 0);
    rst_n = 1'b1;
    first = -1;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      if (div_out && first < 0) first = k;
    end
    check("R1 first pulse within 10 clocks", int'(first > 0), 1);
  endtask

  task automatic t_setting(input string req, input int t, input int u,
                           input int h, input int e, input int v);
    int per, stb, w, p;
    apply(t, u, h, e);
    wait_pulse();
    measure(per, stb, w, p);
    check({req, " R2 period"}, per, 2 * (v + 4));
    check({req, " R6 strobe count"}, stb, v);
    check({req, " R8 single-clock pulse"}, w, 1);
    check({req, " R3 no back-to-back strobe"}, p, 1);
  endtask

  task automatic t_midchange();
    int per, stb, w, p;
    apply(3, 2, 1, 0);            // V=123
    wait_pulse();
    wait_pulse();
    repeat (20) @(negedge clk);   // past the preload, mid countdown
    set_tenths = 4'd0; set_units = 4'd0; set_tens = 4'd5; set_eights = 3'd0;
    per = 0;
    for (int k = 0; k < 40000; k++) begin
      @(negedge clk);
      per++;
      if (div_out) break;
    end
    check("R9 current period keeps old setting", per + 20, 2 * (123 + 4));
    measure(per, stb, w, p);
    check("R9 next period uses new setting", per, 2 * (500 + 4));
  endtask

  initial begin
    t_reset();
    t_setting("R2 zero", 0, 0, 0, 0, 0);
    t_setting("R2 tenths only", 5, 0, 0, 0, 5);
    t_setting("R4 digit weights", 3, 2, 1, 0, 123);
    t_setting("R4 borrow chain", 0, 0, 0, 1, 1000);
    t_setting("R7 clamp units/tenths", 15, 12, 0, 0, 99);
    t_setting("R7 clamp tens", 0, 0, 10, 0, 900);
    t_setting("R2 max", 9, 9, 9, 7, 7999);
    t_midchange();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #(200000 * 5ns);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule